// File: doc/BRIEF.md
# Delay Measurement Sweep Controller

This controller measures the propagation delay of an external device under test by racing two delayed copies of one trigger edge. A reference delay path, held permanently at its smallest setting, launches the edge into the device under test. A second, programmable delay path carries the same edge to the clock input of a capture flip-flop, and that flip-flop samples the device's output. The controller drives the code of the programmable path and reads the captured bit back through `sample_i`. A captured 1 means the programmed delay is longer than the device's delay. A captured 0 means it is shorter.

After a start request, the controller first probes the two ends of the range to detect a delay it cannot bracket. It then runs a binary search over the code, from the most significant bit down. Each decision is taken by a majority vote over an odd number of trials. Each trial is one trigger pulse, a settle wait, and one read of the sample input. At the end, the controller reports the boundary code with a one-cycle completion pulse. The result and the two range flags hold until the next measurement completes.

Top module: `dms_sweep_ctrl`

## Requirements
- R1: While reset is asserted and after its release, before any start, `trig_o`, `done_o`, `max_o`, `over_o` and `under_o` are 0, and `code_o` and `result_o` are all zeros.
- R2: `ref_min_o` is 1 at all times, so the reference path always sits at its minimum delay.
- R3: Each trial drives `trig_o` high for exactly one cycle. `code_o` and `max_o` are unchanged in that cycle compared with the cycle before it, and they stay unchanged until the sample has been read, SETTLE_CYC+1 cycles after the trigger cycle.
- R4: The first batch of TRIALS trials runs with `max_o`=1, which selects a delay one step beyond code 1023 (1024 steps). If every read in that batch is 0, the measurement ends after exactly TRIALS triggers with `over_o`=1, `under_o`=0 and `result_o`=1023.
- R5: The second batch runs with `max_o`=0 and `code_o`=0. If every read in that batch is 1, the measurement ends after exactly 2*TRIALS triggers with `under_o`=1, `over_o`=0 and `result_o`=0.
- R6: Otherwise the controller decides the code bits from bit 9 down to bit 0, one batch per bit, with that bit set on top of the bits already kept. A majority of 1 reads (delay too long) clears the bit. A majority of 0 reads (delay too short) keeps it. The reported `result_o` is the largest code whose majority reads 0. Both flags are 0, and 12*TRIALS triggers are issued in total. For a device whose capture turns to 1 at effective step T (1 ≤ T ≤ 1024), the result is T-1.
- R7: Within one batch, a minority of reads that disagree with the rest does not change the decision.
- R8: `done_o` is a one-cycle pulse at the end of each measurement. `result_o`, `over_o` and `under_o` change only in a cycle where `done_o` is 1.
- R9: A start request that arrives while a measurement is running is ignored. It produces no extra completion pulse and no extra triggers.
- R10: `over_o` and `under_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| sample_i | input | 1 | Captured output of the device under test (1 = programmed delay too long) |
| trig_o | output | 1 | Trigger pulse fed to both delay paths |
| ref_min_o | output | 1 | Forces the reference path to its minimum delay |
| code_o | output | CODE_W | Code of the programmable delay path |
| max_o | output | 1 | Selects the programmable path's maximum setting, overriding `code_o` |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | CODE_W | Measured boundary code |
| over_o | output | 1 | Delay beyond the programmable range |
| under_o | output | 1 | Delay below the smallest code |

## Verification
The bound checker watches the trial protocol on every cycle. It checks that triggers are single-cycle, that the code and the maximum select are steady into each trigger, that the completion pulse is single-cycle, that the result and flags move only at completion, and that the two flags are exclusive. Only the bench's scenarios can show the quantities that depend on the device model. These are the measured code for a given threshold, the correct handling of the two range ends, the trigger count for each outcome, vote resilience against scattered wrong reads, and that a start request issued mid-run has no effect.

// File: rtl/dms_pkg.sv
package dms_pkg;

   // sequencer phases of one measurement
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_CHK_HI = 3'd1,
      PH_CHK_LO = 3'd2,
      PH_SEARCH = 3'd3,
      PH_DONE   = 3'd4
   } seq_ph_e;

   // steps of one trial inside a batch
   typedef enum logic [2:0] {
      TR_IDLE = 3'd0,
      TR_ARM  = 3'd1,
      TR_FIRE = 3'd2,
      TR_WAIT = 3'd3,
      TR_READ = 3'd4
   } trial_st_e;

endpackage

// File: rtl/dms_trial_engine.sv
// Runs one batch of TRIALS trials: fire, settle, read; counts the 1 reads.
module dms_trial_engine
   import dms_pkg::*;
#(
   parameter int TRIALS     = 7,
   parameter int SETTLE_CYC = 4,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             sample_i,
   output logic             trig_o,
   output logic             batch_done_o,
   output logic [CNT_W-1:0] ones_o
);

   localparam int WAIT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0]  RUN_LAST  = CNT_W'(TRIALS - 1);

   trial_st_e         st_q;
   logic [CNT_W-1:0]  run_q;
   logic [CNT_W-1:0]  ones_q;
   logic [WAIT_W-1:0] wait_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TR_IDLE;
         run_q  <= '0;
         ones_q <= '0;
         wait_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            TR_IDLE: begin
               if (go_i) begin
                  st_q   <= TR_ARM;
                  run_q  <= '0;
                  ones_q <= '0;
               end
            end
            TR_ARM: begin
               st_q <= TR_FIRE;
            end
            TR_FIRE: begin
               st_q   <= TR_WAIT;
               wait_q <= '0;
            end
            TR_WAIT: begin
               if (wait_q == WAIT_LAST) begin
                  st_q <= TR_READ;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            TR_READ: begin
               ones_q <= ones_q + CNT_W'(sample_i);
               if (run_q == RUN_LAST) begin
                  st_q   <= TR_IDLE;
                  done_q <= 1'b1;
               end else begin
                  run_q <= run_q + 1'b1;
                  st_q  <= TR_FIRE;
               end
            end
            default: st_q <= TR_IDLE;
         endcase
      end
   end

   assign trig_o       = (st_q == TR_FIRE);
   assign batch_done_o = done_q;
   assign ones_o       = ones_q;

endmodule

// File: rtl/dms_vote.sv
// Turns the count of 1 reads into the batch decisions.
module dms_vote #(
   parameter int TRIALS = 7,
   parameter int CNT_W  = 3
) (
   input  logic [CNT_W-1:0] ones_i,
   output logic             too_long_o,
   output logic             all_long_o,
   output logic             all_short_o
);

   localparam logic [CNT_W-1:0] HALF = CNT_W'(TRIALS / 2);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(TRIALS);

   generate
      if (TRIALS == 1) begin : g_single
         assign too_long_o = ones_i[0];
      end else begin : g_majority
         assign too_long_o = (ones_i > HALF);
      end
   endgenerate

   assign all_long_o  = (ones_i == FULL);
   assign all_short_o = (ones_i == '0);

endmodule

// File: rtl/dms_search_seq.sv
// Range probes, then MSB-first binary search; owns the result registers.
module dms_search_seq
   import dms_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int BIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              batch_done_i,
   input  logic              too_long_i,
   input  logic              all_long_i,
   input  logic              all_short_i,
   output logic              go_o,
   output logic [CODE_W-1:0] code_o,
   output logic              max_o,
   output logic              done_o,
   output logic [CODE_W-1:0] result_o,
   output logic              over_o,
   output logic              under_o
);

   localparam logic [BIT_W-1:0]  TOP_BIT = BIT_W'(CODE_W - 1);
   localparam logic [CODE_W-1:0] TOP_ONE = CODE_W'(1) << (CODE_W - 1);

   seq_ph_e           ph_q;
   logic              pend_q;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] acc_q;
   logic [CODE_W-1:0] res_q;
   logic [BIT_W-1:0]  bit_q;
   logic              over_q;
   logic              under_q;
   logic              probing;
   logic [CODE_W-1:0] keep_v;

   always_comb begin
      probing = (ph_q == PH_CHK_HI) || (ph_q == PH_CHK_LO) || (ph_q == PH_SEARCH);
      keep_v  = too_long_i ? acc_q : code_q;
   end

   assign go_o = probing && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         pend_q  <= 1'b0;
         code_q  <= '0;
         acc_q   <= '0;
         res_q   <= '0;
         bit_q   <= '0;
         over_q  <= 1'b0;
         under_q <= 1'b0;
      end else begin
         if (go_o) begin
            pend_q <= 1'b1;
         end
         if (batch_done_i) begin
            pend_q <= 1'b0;
         end
         case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  ph_q   <= PH_CHK_HI;
                  code_q <= '0;
                  pend_q <= 1'b0;
               end
            end
            PH_CHK_HI: begin
               if (batch_done_i) begin
                  if (all_short_i) begin
                     res_q   <= '1;
                     over_q  <= 1'b1;
                     under_q <= 1'b0;
                     ph_q    <= PH_DONE;
                  end else begin
                     code_q <= '0;
                     ph_q   <= PH_CHK_LO;
                  end
               end
            end
            PH_CHK_LO: begin
               if (batch_done_i) begin
                  if (all_long_i) begin
                     res_q   <= '0;
                     over_q  <= 1'b0;
                     under_q <= 1'b1;
                     ph_q    <= PH_DONE;
                  end else begin
                     acc_q  <= '0;
                     bit_q  <= TOP_BIT;
                     code_q <= TOP_ONE;
                     ph_q   <= PH_SEARCH;
                  end
               end
            end
            PH_SEARCH: begin
               if (batch_done_i) begin
                  if (bit_q == '0) begin
                     res_q   <= keep_v;
                     over_q  <= 1'b0;
                     under_q <= 1'b0;
                     ph_q    <= PH_DONE;
                  end else begin
                     acc_q  <= keep_v;
                     bit_q  <= bit_q - 1'b1;
                     code_q <= keep_v | (CODE_W'(1) << (bit_q - 1'b1));
                  end
               end
            end
            PH_DONE: begin
               ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign code_o   = code_q;
   assign max_o    = (ph_q == PH_CHK_HI);
   assign done_o   = (ph_q == PH_DONE);
   assign result_o = res_q;
   assign over_o   = over_q;
   assign under_o  = under_q;

endmodule

// File: rtl/dms_sweep_ctrl.sv
// Top level: sequencer, trial engine and vote.
module dms_sweep_ctrl #(
   parameter int CODE_W     = 10,
   parameter int TRIALS     = 7,
   parameter int SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sample_i,
   output logic              trig_o,
   output logic              ref_min_o,
   output logic [CODE_W-1:0] code_o,
   output logic              max_o,
   output logic              done_o,
   output logic [CODE_W-1:0] result_o,
   output logic              over_o,
   output logic              under_o
);

   localparam int CNT_W = $clog2(TRIALS + 1);
   localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

   generate
      if (TRIALS < 1 || (TRIALS % 2) == 0) begin : g_bad_trials
         $fatal(1, "TRIALS must be odd and at least 1");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $fatal(1, "SETTLE_CYC must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_code
         $fatal(1, "CODE_W must be at least 2");
      end
   endgenerate

   logic             go;
   logic             batch_done;
   logic [CNT_W-1:0] ones;
   logic             too_long;
   logic             all_long;
   logic             all_short;

   dms_search_seq #(
      .CODE_W (CODE_W),
      .BIT_W  (BIT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .batch_done_i (batch_done),
      .too_long_i   (too_long),
      .all_long_i   (all_long),
      .all_short_i  (all_short),
      .go_o         (go),
      .code_o       (code_o),
      .max_o        (max_o),
      .done_o       (done_o),
      .result_o     (result_o),
      .over_o       (over_o),
      .under_o      (under_o)
   );

   dms_trial_engine #(
      .TRIALS     (TRIALS),
      .SETTLE_CYC (SETTLE_CYC),
      .CNT_W      (CNT_W)
   ) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (go),
      .sample_i     (sample_i),
      .trig_o       (trig_o),
      .batch_done_o (batch_done),
      .ones_o       (ones)
   );

   dms_vote #(
      .TRIALS (TRIALS),
      .CNT_W  (CNT_W)
   ) u_vote (
      .ones_i      (ones),
      .too_long_o  (too_long),
      .all_long_o  (all_long),
      .all_short_o (all_short)
   );

   assign ref_min_o = 1'b1;

endmodule

// File: rtl/dms_sweep_chk.sv
// Protocol checker attached to the top level.
module dms_sweep_chk #(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_o,
   input logic [CODE_W-1:0] code_o,
   input logic              max_o,
   input logic              done_o,
   input logic [CODE_W-1:0] result_o,
   input logic              over_o,
   input logic              under_o
);

   AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o); // R3

   AST_CODE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> ($stable(code_o) && $stable(max_o))); // R3

   AST_CODE_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> ($stable(code_o) && $stable(max_o))); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> done_o); // R8

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(over_o) || !$stable(under_o)) |-> done_o); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(over_o && under_o)); // R10

   AST_NO_TRIG_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !trig_o); // R8

endmodule

bind dms_sweep_ctrl dms_sweep_chk #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trig_o   (trig_o),
   .code_o   (code_o),
   .max_o    (max_o),
   .done_o   (done_o),
   .result_o (result_o),
   .over_o   (over_o),
   .under_o  (under_o)
);

// File: tb/dms_sweep_ctrl_tb.sv
module dms_sweep_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 10;
   localparam int TRIALS     = 7;
   localparam int SETTLE_CYC = 4;

   typedef struct {
      int res;
      bit ov;
      bit un;
      int trigs;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              sample_i;
   logic              trig_o;
   logic              ref_min_o;
   logic [CODE_W-1:0] code_o;
   logic              max_o;
   logic              done_o;
   logic [CODE_W-1:0] result_o;
   logic              over_o;
   logic              under_o;

   int   n_chk = 0;
   int   n_bad = 0;
   int   thr_v = 5000;
   bit   noise_v = 1'b0;
   int   trig_tot = 0;
   int   trig_seen = 0;
   bit   first_max = 1'b0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dms_sweep_ctrl #(
      .CODE_W     (CODE_W),
      .TRIALS     (TRIALS),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .sample_i  (sample_i),
      .trig_o    (trig_o),
      .ref_min_o (ref_min_o),
      .code_o    (code_o),
      .max_o     (max_o),
      .done_o    (done_o),
      .result_o  (result_o),
      .over_o    (over_o),
      .under_o   (under_o)
   );

   // device model: capture reads 1 once the effective step reaches thr_v
   always @(posedge clk) if (trig_o) trig_tot <= trig_tot + 1;

   always_comb begin
      sample_i = (((max_o ? 1024 : int'(code_o)) >= thr_v) ? 1'b1 : 1'b0)
                 ^ (noise_v && (trig_tot % 3 == 0));
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // monitor: pops the scoreboard on each completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (trig_o) begin
            if (trig_seen == 0) first_max = max_o;
            trig_seen = trig_seen + 1;
         end
         if (done_o) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected completion", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R6 result", int'(result_o), e.res);
               check("R4 over flag", int'(over_o), int'(e.ov));
               check("R5 under flag", int'(under_o), int'(e.un));
               check("R6 trigger count", trig_seen, e.trigs);
               check("R4 first batch at max setting", int'(first_max), 1);
               check("R2 reference at minimum", int'(ref_min_o), 1);
            end
            trig_seen = 0;
         end
      end
   end

   // driver: pushes the expectation and runs one measurement
   task automatic measure(input int thr, input bit noisy, input bit poke);
      exp_t e;
      if (thr > 1024) begin
         e.res = 1023; e.ov = 1'b1; e.un = 1'b0; e.trigs = TRIALS;
      end else if (thr == 0) begin
         e.res = 0; e.ov = 1'b0; e.un = 1'b1; e.trigs = 2 * TRIALS;
      end else begin
         e.res = thr - 1; e.ov = 1'b0; e.un = 1'b0; e.trigs = 12 * TRIALS;
      end
      thr_v   = thr;
      noise_v = noisy;
      exp_q.push_back(e);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (poke) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      do @(negedge clk); while (!done_o);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values seen at the ports
      check("R1 trig", int'(trig_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 max", int'(max_o), 0);
      check("R1 code", int'(code_o), 0);
      check("R1 result", int'(result_o), 0);
      check("R1 flags", int'({over_o, under_o}), 0);
      check("R2 reference at minimum in reset", int'(ref_min_o), 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 idle after release", int'({trig_o, done_o, max_o}), 0);

      measure(300, 1'b0, 1'b0);   // R6 mid-range
      measure(1025, 1'b0, 1'b0);  // R4 beyond range
      measure(0, 1'b0, 1'b0);     // R5 below smallest code
      measure(1, 1'b0, 1'b0);     // R6 lower boundary, result 0
      measure(1024, 1'b0, 1'b0);  // R6 upper boundary, result 1023
      measure(513, 1'b1, 1'b0);   // R7 scattered wrong reads
      measure(77, 1'b1, 1'b0);    // R7 scattered wrong reads
      measure(640, 1'b0, 1'b1);   // R9 start while running

      // R9: the ignored start must not launch another run
      repeat (200) @(negedge clk);
      check("R9 no triggers after ignored start", trig_seen, 0);
      check("R9 scoreboard drained", exp_q.size(), 0);
      check("R8 result held while idle", int'(result_o), 639);
      finish_run();
   end

endmodule